// File: doc/BRIEF.md
# Link Retrain Sequencer

This block drives the start-up retraining of one end of a serial chip-to-chip link. A single-cycle start pulse launches a fixed program of register accesses. The program first limits the advertised top speed to the second generation, using a read-modify-write of a write-once capability register. It then takes a snapshot of the link status. Finally it runs two retrain rounds in a row. Each round sets a retrain request with a read-modify-write of the link-control register, then polls the link-status register until the training flag clears.

The block reports the negotiated speed generation and lane width three times on a status output: once before the first retrain and once after each retrain. This lets software or a neighbouring block log how the link came up. All accesses go through a simple request/acknowledge register port with one access outstanding at a time.

A programmable poll limit guards every training wait. If the training flag stays set too long, the sequencer stops and raises an error flag.

Top module: `lrs_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, req_o and stat_valid_o are all 0.
- R2: A start pulse while idle makes the first access a read of CAP_ADDR (default 0). The second access is a write to CAP_ADDR of the value read, with mask 0x3F00F cleared and the value 2 placed in bits [3:0].
- R3: The third access is a read of STS_ADDR (default 2). Its result is reported as a one-cycle stat_valid_o pulse with stat_idx_o = 0, stat_gen_o = status bits [3:0] and stat_width_o = status bits [8:4].
- R4: Each retrain round reads CTL_ADDR (default 1) and then writes back the same value with bit 5 set. All other bits are kept.
- R5: After each retrain write, STS_ADDR is read repeatedly until a read returns bit 11 = 0. That read is reported as stat_idx_o = 1 for the first round and 2 for the second, with the field positions of R3.
- R6: Exactly two retrain rounds run. After the second round's report, done_o rises and busy_o falls in the same cycle. done_o stays high until the next accepted start.
- R7: Within one training wait, the N-th consecutive status read that shows bit 11 = 1 sets err_o and returns the block to idle with no further access. N is timeout_lim_i, and a limit of 0 counts as 1. err_o stays high until the next accepted start, and done_o is not raised.
- R8: A start pulse while busy_o is 1 is ignored. The sequence still makes exactly two capability accesses and two control writes.
- R9: req_o stays high with stable addr_o, we_o and wdata_o until ack_i. Only one access is outstanding, and read data is taken in the ack_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| timeout_lim_i | input | TW | Busy status reads allowed per training wait |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | AW | Register address |
| wdata_o | output | DW | Write data |
| rdata_i | input | DW | Read data, valid with ack_i |
| ack_i | input | 1 | Access completion, one cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Both retrains completed |
| err_o | output | 1 | A training wait hit the poll limit |
| stat_valid_o | output | 1 | Link status report pulse |
| stat_idx_o | output | 2 | Report index: 0 before, 1 and 2 after each retrain |
| stat_gen_o | output | 4 | Reported speed generation |
| stat_width_o | output | 5 | Reported lane width |

## Verification
The assertions assume that the far side of the register port behaves as a well-formed target. It raises ack_i for a single cycle per access, only while req_o is high and never in two consecutive cycles, and it presents read data in that same cycle. The bench's link model keeps to this: it acknowledges after a configurable latency of zero to two idle cycles and always drops ack_i for at least one cycle. The assertions also take start_i as a short pulse, and the bench drives it for one cycle at a time, including the extra pulse sent mid-sequence.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAP_RD,
        ST_CAP_WR,
        ST_SNAP,
        ST_CTL_RD,
        ST_CTL_WR,
        ST_POLL
    } lrs_state_e;

    localparam int unsigned CTL_RETRAIN_BIT = 5;
    localparam int unsigned STS_TRAIN_BIT   = 11;
    localparam int unsigned GEN_W           = 4;
    localparam int unsigned WID_W           = 5;
    localparam int unsigned WID_LSB         = 4;
    localparam int unsigned IDX_W           = 2;
    localparam logic [31:0] CAP_CLR_MASK    = 32'h0003_F00F;
    localparam logic [31:0] CAP_SPEED_VAL   = 32'h0000_0002;

endpackage

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          busy_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);

    localparam int unsigned CW = TW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] eff_lim;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        eff_lim  = (limit_i == '0) ? CW'(1) : CW'(limit_i);
        cnt_inc  = cnt_q + CW'(1);
        expire_o = busy_i && (cnt_inc >= eff_lim);
        cnt_d    = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (busy_i && !expire_o) begin
            cnt_d = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lrs_stat_cap.sv
module lrs_stat_cap
    import lrs_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [DW-1:0]    word_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [GEN_W-1:0] gen_o,
    output logic [WID_W-1:0] width_o
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [GEN_W-1:0] gen;
        logic [WID_W-1:0] width;
    } cap_t;

    cap_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = load_i;
        if (load_i) begin
            r_d.idx   = idx_i;
            r_d.gen   = word_i[GEN_W-1:0];
            r_d.width = word_i[WID_LSB +: WID_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o = r_q.valid;
    assign idx_o   = r_q.idx;
    assign gen_o   = r_q.gen;
    assign width_o = r_q.width;

endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
    import lrs_pkg::*;
#(
    parameter int unsigned AW       = 4,
    parameter int unsigned DW       = 32,
    parameter int unsigned TW       = 16,
    parameter logic [AW-1:0] CAP_ADDR = 4'd0,
    parameter logic [AW-1:0] CTL_ADDR = 4'd1,
    parameter logic [AW-1:0] STS_ADDR = 4'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TW-1:0]    timeout_lim_i,
    output logic             req_o,
    output logic             we_o,
    output logic [AW-1:0]    addr_o,
    output logic [DW-1:0]    wdata_o,
    input  logic [DW-1:0]    rdata_i,
    input  logic             ack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             stat_valid_o,
    output logic [IDX_W-1:0] stat_idx_o,
    output logic [GEN_W-1:0] stat_gen_o,
    output logic [WID_W-1:0] stat_width_o
);

    localparam logic [DW-1:0] CAP_MASK  = DW'(CAP_CLR_MASK);
    localparam logic [DW-1:0] CAP_SET   = DW'(CAP_SPEED_VAL);
    localparam logic [DW-1:0] RETRAIN_M = DW'(1) << CTL_RETRAIN_BIT;

    typedef struct packed {
        lrs_state_e    st;
        logic          pass;
        logic [DW-1:0] rd;
        logic          done;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;

    logic             tmr_clr;
    logic             tmr_busy;
    logic             tmr_expire;
    logic             cap_load;
    logic [IDX_W-1:0] cap_idx;

    always_comb begin
        s_d      = s_q;
        req_o    = 1'b0;
        we_o     = 1'b0;
        addr_o   = '0;
        wdata_o  = '0;
        tmr_clr  = 1'b0;
        tmr_busy = 1'b0;
        cap_load = 1'b0;
        cap_idx  = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_CAP_RD;
                    s_d.done = 1'b0;
                    s_d.err  = 1'b0;
                    s_d.pass = 1'b0;
                    tmr_clr  = 1'b1;
                end
            end
            ST_CAP_RD: begin
                req_o  = 1'b1;
                addr_o = CAP_ADDR;
                if (ack_i) begin
                    s_d.rd = rdata_i;
                    s_d.st = ST_CAP_WR;
                end
            end
            ST_CAP_WR: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = CAP_ADDR;
                wdata_o = (s_q.rd & ~CAP_MASK) | CAP_SET;
                if (ack_i) begin
                    s_d.st = ST_SNAP;
                end
            end
            ST_SNAP: begin
                req_o  = 1'b1;
                addr_o = STS_ADDR;
                if (ack_i) begin
                    cap_load = 1'b1;
                    cap_idx  = IDX_W'(0);
                    s_d.pass = 1'b0;
                    s_d.st   = ST_CTL_RD;
                end
            end
            ST_CTL_RD: begin
                req_o  = 1'b1;
                addr_o = CTL_ADDR;
                if (ack_i) begin
                    s_d.rd = rdata_i;
                    s_d.st = ST_CTL_WR;
                end
            end
            ST_CTL_WR: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = CTL_ADDR;
                wdata_o = s_q.rd | RETRAIN_M;
                if (ack_i) begin
                    tmr_clr = 1'b1;
                    s_d.st  = ST_POLL;
                end
            end
            ST_POLL: begin
                req_o  = 1'b1;
                addr_o = STS_ADDR;
                if (ack_i) begin
                    if (!rdata_i[STS_TRAIN_BIT]) begin
                        cap_load = 1'b1;
                        cap_idx  = s_q.pass ? IDX_W'(2) : IDX_W'(1);
                        if (s_q.pass) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end else begin
                            s_d.pass = 1'b1;
                            s_d.st   = ST_CTL_RD;
                        end
                    end else begin
                        tmr_busy = 1'b1;
                        if (tmr_expire) begin
                            s_d.err = 1'b1;
                            s_d.st  = ST_IDLE;
                        end
                    end
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, pass: 1'b0, rd: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    lrs_wait_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tmr_clr),
        .busy_i   (tmr_busy),
        .limit_i  (timeout_lim_i),
        .expire_o (tmr_expire)
    );

    lrs_stat_cap #(
        .DW (DW)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cap_load),
        .idx_i   (cap_idx),
        .word_i  (rdata_i),
        .valid_o (stat_valid_o),
        .idx_o   (stat_idx_o),
        .gen_o   (stat_gen_o),
        .width_o (stat_width_o)
    );

    assign busy_o = (s_q.st != ST_IDLE);
    assign done_o = s_q.done;
    assign err_o  = s_q.err;

endmodule

// File: rtl/lrs_seq_chk.sv
module lrs_seq_chk
    import lrs_pkg::*;
#(
    parameter int unsigned AW       = 4,
    parameter int unsigned DW       = 32,
    parameter int unsigned TW       = 16,
    parameter logic [AW-1:0] CAP_ADDR = 4'd0,
    parameter logic [AW-1:0] CTL_ADDR = 4'd1,
    parameter logic [AW-1:0] STS_ADDR = 4'd2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_o,
    input logic             we_o,
    input logic [AW-1:0]    addr_o,
    input logic [DW-1:0]    wdata_o,
    input logic             ack_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic             stat_valid_o,
    input logic [IDX_W-1:0] stat_idx_o
);

    localparam logic [DW-1:0] KEEP_ZERO = DW'(CAP_CLR_MASK & ~CAP_SPEED_VAL);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));

    a_r2_cap_write_value: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && we_o && (addr_o == CAP_ADDR) |->
            ((wdata_o & KEEP_ZERO) == '0) && (wdata_o[3:0] == 4'd2));

    a_r4_retrain_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && we_o && (addr_o == CTL_ADDR) |-> wdata_o[CTL_RETRAIN_BIT]);

    a_r6_done_with_last_report: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> stat_valid_o && (stat_idx_o == IDX_W'(2)) && !busy_o);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r7_error_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !req_o && !busy_o);

    a_r5_status_reads_only_poll: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && (addr_o == STS_ADDR) |-> !we_o);

endmodule

bind lrs_seq lrs_seq_chk #(
    .AW (AW), .DW (DW), .TW (TW),
    .CAP_ADDR (CAP_ADDR), .CTL_ADDR (CTL_ADDR), .STS_ADDR (STS_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_o        (req_o),
    .we_o         (we_o),
    .addr_o       (addr_o),
    .wdata_o      (wdata_o),
    .ack_i        (ack_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .stat_valid_o (stat_valid_o),
    .stat_idx_o   (stat_idx_o)
);

// File: tb/tb_lrs_seq.sv
module tb_lrs_seq;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [TW-1:0] lim = '0;
    logic          req, we, ack;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic          busy, done, err, sv;
    logic [1:0]    sidx;
    logic [3:0]    sgen;
    logic [4:0]    swid;

    always #10 clk = ~clk;

    lrs_seq dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .timeout_lim_i (lim),
        .req_o (req), .we_o (we), .addr_o (addr), .wdata_o (wdata),
        .rdata_i (rdata), .ack_i (ack), .busy_o (busy), .done_o (done),
        .err_o (err), .stat_valid_o (sv), .stat_idx_o (sidx),
        .stat_gen_o (sgen), .stat_width_o (swid)
    );

    // link model configuration
    logic       minit = 1'b0;
    int         m_lat = 0, m_train = 0, m_maxg = 1, m_lanes = 1;

    // link model state
    logic [31:0] cap_r, ctl_r;
    logic [3:0]  gen_r;
    logic [4:0]  wid_r;
    int          left, lcnt, rounds;
    int          n_acc, n_capwr, n_ctlwr;
    logic [31:0] last_cap, last_ctl;

    always_ff @(posedge clk) begin
        if (minit) begin
            cap_r <= 32'hFFFF_FFFF; ctl_r <= 32'h0000_1A0F;
            gen_r <= 4'd1; wid_r <= 5'd1; left <= 0; lcnt <= 0; rounds <= 0;
            n_acc <= 0; n_capwr <= 0; n_ctlwr <= 0;
            last_cap <= '0; last_ctl <= '0; ack <= 1'b0; rdata <= '0;
        end else if (req && !ack) begin
            if (lcnt == m_lat) begin
                ack   <= 1'b1;
                lcnt  <= 0;
                n_acc <= n_acc + 1;
                if (we) begin
                    if (addr == 4'd0) begin
                        cap_r <= wdata; last_cap <= wdata; n_capwr <= n_capwr + 1;
                    end else if (addr == 4'd1) begin
                        ctl_r <= wdata & ~32'h20; last_ctl <= wdata; n_ctlwr <= n_ctlwr + 1;
                        if (wdata[5]) begin
                            left   <= m_train;
                            rounds <= rounds + 1;
                            gen_r  <= (cap_r[3:0] < 4'(m_maxg)) ? cap_r[3:0] : 4'(m_maxg);
                            wid_r  <= 5'(m_lanes << rounds);
                        end
                    end
                end else begin
                    if (addr == 4'd0) rdata <= cap_r;
                    else if (addr == 4'd1) rdata <= ctl_r;
                    else begin
                        rdata <= {20'd0, (left != 0), 2'b00, wid_r, gen_r};
                        if (left != 0) left <= left - 1;
                    end
                end
            end else begin
                lcnt <= lcnt + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end

    // report monitor
    int   n_rep;
    logic [3:0] rep_gen [3];
    logic [4:0] rep_wid [3];
    logic [1:0] rep_idx [3];
    always @(negedge clk) begin
        if (minit) n_rep = 0;
        else if (sv) begin
            if (n_rep < 3) begin
                rep_gen[n_rep] = sgen; rep_wid[n_rep] = swid; rep_idx[n_rep] = sidx;
            end
            n_rep = n_rep + 1;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input int lat, input int tr, input int maxg, input int lanes,
                            input int limit, input bit expect_err);
        bit fin = 0;
        int eg, ew1, ew2, eacc;
        @(negedge clk);
        m_lat = lat; m_train = tr; m_maxg = maxg; m_lanes = lanes; lim = TW'(limit);
        minit = 1'b1;
        @(negedge clk);
        minit = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        // R8: extra start while busy
        check(busy == 1'b1, "R8 busy at second start", busy, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 3000 && !fin; c++) begin
            if (done || err) fin = 1;
            else @(negedge clk);
        end
        check(fin, "R6 sequence finished (watchdog)", fin, 1);
        repeat (4) @(negedge clk);
        eg  = (maxg < 2) ? maxg : 2;
        ew1 = lanes;
        ew2 = lanes * 2;
        if (!expect_err) begin
            eacc = 3 + 2 * (tr + 3);
            check(done && !err && !busy, "R6 done held, idle", {done, err, busy}, 3'b100);
            check(n_rep == 3, "R5 report count", n_rep, 3);
            check(rep_idx[0] == 0 && rep_gen[0] == 1 && rep_wid[0] == 1, "R3 snapshot",
                  {rep_idx[0], rep_gen[0], rep_wid[0]}, {2'd0, 4'd1, 5'd1});
            check(rep_idx[1] == 1 && rep_gen[1] == 4'(eg) && rep_wid[1] == 5'(ew1), "R5 first retrain report",
                  {rep_idx[1], rep_gen[1], rep_wid[1]}, {2'd1, 4'(eg), 5'(ew1)});
            check(rep_idx[2] == 2 && rep_gen[2] == 4'(eg) && rep_wid[2] == 5'(ew2), "R5 second retrain report",
                  {rep_idx[2], rep_gen[2], rep_wid[2]}, {2'd2, 4'(eg), 5'(ew2)});
            check(n_ctlwr == 2, "R8 R6 control write count", n_ctlwr, 2);
            check(last_ctl == 32'h0000_1A2F, "R4 control write value", last_ctl, 32'h1A2F);
        end else begin
            eacc = 5 + ((limit == 0) ? 1 : limit);
            check(err && !done && !busy, "R7 error held, idle", {done, err, busy}, 3'b010);
            check(n_rep == 1, "R7 only snapshot reported", n_rep, 1);
            check(n_ctlwr == 1, "R7 one control write", n_ctlwr, 1);
        end
        check(n_acc == eacc, "R7 R9 access count", n_acc, eacc);
        check(n_capwr == 1, "R8 capability write count", n_capwr, 1);
        check(last_cap == 32'hFFFC_0FF2, "R2 capability write value", last_cap, 32'hFFFC0FF2);
    endtask

    initial begin
        minit = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !req && !sv, "R1 reset outputs",
              {busy, done, err, req, sv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !req && !sv, "R1 after release",
              {busy, done, err, req, sv}, 0);
        minit = 1'b0;
        for (int l = 0; l < 3; l++)
            for (int t = 0; t < 4; t++)
                for (int g = 1; g < 4; g++)
                    run_case(l, t, g, 1 << (g - 1), t + 1, 1'b0);
        // R7: limit 0 behaves as 1, no busy reads needed when training length is 0
        run_case(0, 0, 2, 2, 0, 1'b0);
        for (int l = 0; l < 3; l++)
            for (int t = 1; t < 4; t++)
                for (int m = 0; m <= t; m++)
                    run_case(l, t, 2, 1, m, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule